// File: doc/BRIEF.md
# Status Flag Interrupt Vector and DMA Request Unit

This unit gathers single-cycle event strobes from a serial bus controller's sequencer and data buffer into a word of sticky status flags. Five of those flags (the low bits 4:0) can be enabled to raise one level-sensitive interrupt. Two DMA request lines can be enabled to follow the receive-ready and transmit-ready flags. The unit does not contain an interrupt controller or a DMA engine.

Software reaches the unit through a small 16-bit register port with four word addresses: 0 interrupt enable, 1 status, 2 vector, 3 DMA configuration. Read data is combinational from the address while `rd_en` is high. Any state change that a read causes takes effect at the clock edge that ends the read cycle. The vector register returns a number that identifies the lowest pending enabled source, and reading it acknowledges that source. The status read also shows a live bus-busy level that is never stored.

Status bit map: 1 = no-acknowledge, 2 = access-ready, 3 = receive-ready, 4 = transmit-ready, 9 = addressed-as-target, 10 = transmit underflow, 11 = receive overrun, 12 = bus busy (live input), 15 = single-byte data. Bits 0, 5 to 8, 13 and 14 always read zero.

Top module: `flag_irq_dma_unit`

## Requirements
- R1: After reset the status, interrupt enable and DMA configuration read as zero, and `irq`, `rx_dreq` and `tx_dreq` are low.
- R2: A high bit of `evt_set` sets the matching status flag at the next clock edge, but only at bits 1, 2, 3, 4, 9, 10, 11 and 15. The flag then stays set. The other bits of `evt_set` are never stored.
- R3: Bit 12 of the status read (address 1) equals the `bus_busy` input in the same cycle.
- R4: A write to address 0 keeps only bits 4:0 as the interrupt enable. Bits 15:5 of that register read as zero.
- R5: `irq` is high exactly while some status bit among 4:0 is set and its enable bit is also set.
- R6: A read of address 2 returns 1 plus the index of the lowest set bit of (status AND enable), or 0 when none is set. That status bit is cleared at the edge that ends the read.
- R7: If an event strobe and a vector-read acknowledge hit the same flag in the same cycle, the flag stays set.
- R8: A write to address 3 keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). All other bits of that register read as zero.
- R9: A write to address 3 with bit 15 set clears interrupt enable bit 3. A write with bit 7 set clears interrupt enable bit 4.
- R10: `rx_dreq` equals status bit 3 while receive DMA is enabled and is low otherwise. `tx_dreq` equals status bit 4 while transmit DMA is enabled and is low otherwise.
- R11: Writes to address 1 and address 2 leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register word address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; needed for the vector acknowledge |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| evt_set | input | 16 | One-cycle strobes that set status flags |
| bus_busy | input | 1 | Live bus-busy level |
| irq | output | 1 | Level interrupt |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |

## Verification
The vector is read with several flags pending under different enable masks. One run has every source enabled, so the lowest pending flag must win. Another enables only a higher source, which shows that the lowest-bit search is taken after masking. A repeated read until zero confirms that each read clears exactly one flag. The interrupt is checked with a disabled flag pending and then with an enabled one, to separate masking from the flags themselves. A same-cycle strobe and acknowledge on one flag exercises set priority. The DMA lines are watched with their flags set and the channels switched on and then off.

// File: rtl/flag_irq_dma_unit.sv
module flag_irq_dma_unit #(
  parameter int DW = 16,
  parameter int AW = 2,
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] evt_set,
  input  logic          bus_busy,
  output logic          irq,
  output logic          rx_dreq,
  output logic          tx_dreq
);
  localparam logic [AW-1:0] A_IEN = 2'd0;
  localparam logic [AW-1:0] A_STAT = 2'd1;
  localparam logic [AW-1:0] A_VEC = 2'd2;
  localparam logic [AW-1:0] A_DMA = 2'd3;
  localparam logic [DW-1:0] KEEP = 16'h8E1E;
  localparam int RXB = 3;
  localparam int TXB = 4;
  localparam int BUSYB = 12;
  localparam int RX_EN_B = 15;
  localparam int TX_EN_B = 7;
  localparam int VW = $clog2(EW + 1);

  logic [DW-1:0] stat_q, clr_mask, stat_d;
  logic [EW-1:0] ien_q, pend;
  logic          dma_rx_q, dma_tx_q;
  logic [VW-1:0] vec_num;
  logic          vec_ack;
  logic          unused_wdata;

  assign unused_wdata = ^wdata;
  assign pend = stat_q[EW-1:0] & ien_q;
  assign irq = |pend;
  assign rx_dreq = dma_rx_q & stat_q[RXB];
  assign tx_dreq = dma_tx_q & stat_q[TXB];

  always_comb begin
    vec_num = '0;
    for (int i = EW - 1; i >= 0; i--)
      if (pend[i]) vec_num = VW'(i + 1);
  end

  assign vec_ack = rd_en && addr == A_VEC && vec_num != '0;
  assign clr_mask = vec_ack ? (DW'(1) << (vec_num - VW'(1))) : '0;
  assign stat_d = (stat_q & ~clr_mask) | (evt_set & KEEP);

  always_comb begin
    rdata = '0;
    case (addr)
      A_IEN:  rdata = DW'(ien_q);
      A_STAT: begin
        rdata = stat_q;
        rdata[BUSYB] = bus_busy;
      end
      A_VEC:  rdata = DW'(vec_num);
      default: begin
        rdata[RX_EN_B] = dma_rx_q;
        rdata[TX_EN_B] = dma_tx_q;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q <= '0;
      dma_rx_q <= 1'b0;
      dma_tx_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      if (wr_en && addr == A_IEN) ien_q <= wdata[EW-1:0];
      if (wr_en && addr == A_DMA) begin
        dma_rx_q <= wdata[RX_EN_B];
        dma_tx_q <= wdata[TX_EN_B];
        if (wdata[RX_EN_B]) ien_q[RXB] <= 1'b0;
        if (wdata[TX_EN_B]) ien_q[TXB] <= 1'b0;
      end
    end
  end

  p_sticky_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & KEEP) != '0) |=> ((stat_q & $past(evt_set & KEEP)) == $past(evt_set & KEEP)));

  p_vec_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && evt_set == '0) |=> ((stat_q & $past(clr_mask)) == '0));

  p_vec_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_VEC && rdata == '0) |-> !irq);

  p_dma_clears_ien_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DMA && wdata[RX_EN_B]) |=> !ien_q[RXB]);

  p_readonly_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_STAT || addr == A_VEC) && evt_set == '0 && !vec_ack) |=> $stable(stat_q));
endmodule

// File: tb/tb_flag_irq_dma_unit.sv
module tb_flag_irq_dma_unit;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, bus_busy = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, evt_set = 0, rdata;
  logic irq, rx_dreq, tx_dreq;
  int checks = 0, fails = 0;
  logic [15:0] v;

  always #2.5 clk = ~clk;

  flag_irq_dma_unit dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .evt_set(evt_set), .bus_busy(bus_busy), .irq(irq),
    .rx_dreq(rx_dreq), .tx_dreq(tx_dreq));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; evt_set = 0; wr_en = 0; rd_en = 0; bus_busy = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic evt(logic [15:0] m);
    @(negedge clk); evt_set = m;
    @(negedge clk); evt_set = 0;
  endtask

  task automatic t_reset();
    do_reset();
    rd(1, v); chk("R1 status", v, 16'h0);
    rd(0, v); chk("R1 enable", v, 16'h0);
    rd(3, v); chk("R1 dma", v, 16'h0);
    chk("R1 outputs", {13'h0, irq, rx_dreq, tx_dreq}, 16'h0);
  endtask

  task automatic t_flags();
    do_reset();
    evt(16'hFFFF);
    rd(1, v); chk("R2 stored bits", v, 16'h8E1E);
    @(negedge clk); bus_busy = 1;
    rd(1, v); chk("R3 busy high", v, 16'h9E1E);
    @(negedge clk); bus_busy = 0;
    rd(1, v); chk("R3 busy low", v, 16'h8E1E);
  endtask

  task automatic t_enable();
    do_reset();
    wr(0, 16'hFFFF); rd(0, v); chk("R4 enable width", v, 16'h001F);
  endtask

  task automatic t_irq();
    do_reset();
    wr(0, 16'h0004);
    evt(16'h0002); #1 chk("R5 masked flag", {15'h0, irq}, 16'h0);
    evt(16'h0004); #1 chk("R5 enabled flag", {15'h0, irq}, 16'h1);
  endtask

  task automatic t_vector();
    do_reset();
    wr(0, 16'h001F); evt(16'h0014);
    rd(2, v); chk("R6 lowest first", v, 16'd3);
    rd(1, v); chk("R6 acked bit cleared", v, 16'h0010);
    rd(2, v); chk("R6 next", v, 16'd5);
    rd(2, v); chk("R6 none", v, 16'd0);
    #1 chk("R6 irq low", {15'h0, irq}, 16'h0);
    do_reset();
    wr(0, 16'h0010); evt(16'h0014);
    rd(2, v); chk("R6 mask before search", v, 16'd5);
  endtask

  task automatic t_set_wins();
    do_reset();
    wr(0, 16'h001F); evt(16'h0002);
    @(negedge clk); addr = 2; rd_en = 1; evt_set = 16'h0002; #1 v = rdata;
    @(negedge clk); rd_en = 0; evt_set = 0;
    chk("R7 vector value", v, 16'd2);
    rd(1, v); chk("R7 flag kept", v, 16'h0002);
  endtask

  task automatic t_dma_cfg();
    do_reset();
    wr(3, 16'hFFFF); rd(3, v); chk("R8 dma width", v, 16'h8080);
    wr(3, 16'h0000); wr(0, 16'h001F);
    wr(3, 16'h8000); rd(0, v); chk("R9 rx clears en3", v, 16'h0017);
    wr(0, 16'h001F);
    wr(3, 16'h0080); rd(0, v); chk("R9 tx clears en4", v, 16'h000F);
  endtask

  task automatic t_dreq();
    do_reset();
    evt(16'h0008); #1 chk("R10 rx off", {14'h0, rx_dreq, tx_dreq}, 16'h0);
    wr(3, 16'h8080); #1 chk("R10 rx on", {14'h0, rx_dreq, tx_dreq}, 16'h2);
    evt(16'h0010); #1 chk("R10 both", {14'h0, rx_dreq, tx_dreq}, 16'h3);
    wr(3, 16'h0000); #1 chk("R10 disabled", {14'h0, rx_dreq, tx_dreq}, 16'h0);
  endtask

  task automatic t_readonly();
    do_reset();
    evt(16'h0004);
    wr(1, 16'hFFFF); wr(2, 16'hFFFF);
    rd(1, v); chk("R11 status unchanged", v, 16'h0004);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_flags(); t_enable(); t_irq(); t_vector();
        t_set_wins(); t_dma_cfg(); t_dreq(); t_readonly();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule